// File: doc/BRIEF.md
# Memory Region Hazard Scoreboard

This block sits between a processor pipeline and a memory-to-memory accelerator so the two can run at once. Every accelerator operation copies-and-transforms one memory block into another. Each block is given as a base address and a power-of-two size (log2 of the byte count). While an operation is in flight, its two regions are held in a small table.

Every processor load and store is compared against the table and stalled when it would break program order. Every newly issued operation is compared the same way against older ones. The effect is that all memory traffic appears to run in issue order, while unrelated processor work keeps flowing.

The block also keeps a small set of accelerator contexts. Each context holds one of the loadable functions. An issue whose function is not resident starts a fill, and the fill replaces the least recently used context. The control state machine has two states:
- `S_RUN`: normal issue.
- `S_FILL`: a context is being loaded.

It has three transitions:
- `S_RUN -> S_FILL`: a request misses the contexts.
- `S_FILL -> S_FILL`: the fill counter has not reached zero.
- `S_FILL -> S_RUN`: the fill completes and the function is installed.

Top module: `mrh_scoreboard`

## Requirements
- R1: After reset the table is empty: no processor access stalls, no grant or fill is shown, and no function is resident, so the first issue misses.
- R2: A processor load (cpu_we=0) stalls while it overlaps the destination region of an in-flight operation; overlapping only a source region does not stall it.
- R3: A processor store (cpu_we=1) stalls while it overlaps either the source or the destination region of an in-flight operation.
- R4: Two regions overlap when their addresses agree after both are shifted right by the larger of the two log2 sizes; a processor access counts as size 1 (log2 0).
- R5: A new operation stalls when its source overlaps an in-flight destination, when its destination overlaps an in-flight source, or when its destination overlaps an in-flight destination. Otherwise it is granted in the same cycle with acc_tag set to the lowest free entry.
- R6: The table has 4 entries. An issue stalls while all 4 are in use. A done_valid pulse frees entry done_tag at the next clock edge, so an issue made in the same cycle as the pulse still stalls and is granted one cycle later.
- R7: A completion removes only its own entry's regions. A processor access that stalled on that entry is released in the cycle after the done pulse, and accesses still overlapping other entries keep stalling.
- R8: An issue whose function is not resident stalls. The machine then spends exactly 4 cycles in S_FILL with ctx_fill=1, reporting the target context in ctx_fill_slot and the function in ctx_fill_fn. The held request is granted in the first cycle back in S_RUN.
- R9: A fill replaces the context whose function was least recently granted or installed. After reset the replacement order is context 3, 2, 1, 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor memory access present this cycle |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | AW | Processor byte address |
| cpu_stall | output | 1 | Processor access must be held |
| acc_req | input | 1 | Accelerator operation offered for issue |
| acc_fn | input | FNW | Function number (0 to 13) |
| acc_src | input | AW | Source block base |
| acc_src_lg | input | LGW | log2 of source block size |
| acc_dst | input | AW | Destination block base |
| acc_dst_lg | input | LGW | log2 of destination block size |
| acc_stall | output | 1 | Offered operation not accepted this cycle |
| acc_grant | output | 1 | Operation accepted this cycle |
| acc_tag | output | TW | Table entry given to the accepted operation |
| done_valid | input | 1 | Completion pulse from the accelerator |
| done_tag | input | TW | Entry that completed |
| ctx_fill | output | 1 | A context load is in progress |
| ctx_fill_slot | output | CW | Context being loaded |
| ctx_fill_fn | output | FNW | Function being loaded |

## Verification
Two events can meet in one cycle: a completion pulse that frees an entry, and both a new issue against a full table and a processor load against the completing entry's destination. The bench fills all four entries. In a single cycle it then raises done_valid for one of them, offers a fifth disjoint operation and presents a load into the completing destination. It expects both the issue and the load to stall in that cycle. One cycle later it expects the issue to be granted the freed tag and the load to be released.

// File: rtl/mrh_pkg.sv
package mrh_pkg;

    typedef enum logic [0:0] {
        S_RUN  = 1'b0,
        S_FILL = 1'b1
    } sb_state_e;

    // Regions are aligned power-of-two blocks: compare the bits above the
    // larger block size.
    function automatic logic regions_overlap(
        input logic [31:0] a_base,
        input logic [4:0]  a_lg,
        input logic [31:0] b_base,
        input logic [4:0]  b_lg
    );
        logic [4:0] sh;
        sh = (a_lg > b_lg) ? a_lg : b_lg;
        return (a_base >> sh) == (b_base >> sh);
    endfunction

endpackage

// File: rtl/mrh_region_table.sv
module mrh_region_table
    import mrh_pkg::*;
#(
    parameter int AW   = 16,
    parameter int LGW  = 4,
    parameter int NENT = 4,
    localparam int TW  = $clog2(NENT)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           alloc_i,
    input  logic [AW-1:0]  alloc_src_i,
    input  logic [LGW-1:0] alloc_src_lg_i,
    input  logic [AW-1:0]  alloc_dst_i,
    input  logic [LGW-1:0] alloc_dst_lg_i,
    input  logic           done_i,
    input  logic [TW-1:0]  done_tag_i,
    input  logic           cpu_req_i,
    input  logic           cpu_we_i,
    input  logic [AW-1:0]  cpu_addr_i,
    output logic           cpu_hit_o,
    input  logic [AW-1:0]  chk_src_i,
    input  logic [LGW-1:0] chk_src_lg_i,
    input  logic [AW-1:0]  chk_dst_i,
    input  logic [LGW-1:0] chk_dst_lg_i,
    output logic           op_hazard_o,
    output logic           full_o,
    output logic [TW-1:0]  free_tag_o
);

    logic [NENT-1:0] vld_vec;
    logic [NENT-1:0] cpu_hit_vec;
    logic [NENT-1:0] haz_vec;

    for (genvar g = 0; g < NENT; g++) begin : g_ent
        logic           vld;
        logic [AW-1:0]  src;
        logic [LGW-1:0] src_lg;
        logic [AW-1:0]  dst;
        logic [LGW-1:0] dst_lg;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld    <= 1'b0;
                src    <= '0;
                src_lg <= '0;
                dst    <= '0;
                dst_lg <= '0;
            end else if (alloc_i && free_tag_o == TW'(g)) begin
                vld    <= 1'b1;
                src    <= alloc_src_i;
                src_lg <= alloc_src_lg_i;
                dst    <= alloc_dst_i;
                dst_lg <= alloc_dst_lg_i;
            end else if (done_i && done_tag_i == TW'(g)) begin
                vld    <= 1'b0;
            end
        end

        logic cpu_vs_src, cpu_vs_dst;
        logic raw, war, waw;

        always_comb begin
            cpu_vs_src = regions_overlap(32'(cpu_addr_i), 5'd0, 32'(src), 5'(src_lg));
            cpu_vs_dst = regions_overlap(32'(cpu_addr_i), 5'd0, 32'(dst), 5'(dst_lg));
            raw = regions_overlap(32'(chk_src_i), 5'(chk_src_lg_i), 32'(dst), 5'(dst_lg));
            war = regions_overlap(32'(chk_dst_i), 5'(chk_dst_lg_i), 32'(src), 5'(src_lg));
            waw = regions_overlap(32'(chk_dst_i), 5'(chk_dst_lg_i), 32'(dst), 5'(dst_lg));
        end

        assign vld_vec[g]     = vld;
        assign cpu_hit_vec[g] = vld && cpu_req_i && (cpu_vs_dst || (cpu_we_i && cpu_vs_src));
        assign haz_vec[g]     = vld && (raw || war || waw);
    end

    always_comb begin
        free_tag_o = '0;
        for (int i = NENT - 1; i >= 0; i--) begin
            if (!vld_vec[i]) free_tag_o = TW'(i);
        end
    end

    assign full_o      = &vld_vec;
    assign cpu_hit_o   = |cpu_hit_vec;
    assign op_hazard_o = |haz_vec;

    // R6
    no_alloc_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> !full_o);

    // R6
    done_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && vld_vec[done_tag_i]) |=> !vld_vec[$past(done_tag_i)]);

    // R6
    alloc_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |=> vld_vec[$past(free_tag_o)]);

endmodule

// File: rtl/mrh_ctx_lru.sv
module mrh_ctx_lru #(
    parameter int NCTX = 4,
    parameter int FNW  = 4,
    localparam int CW  = $clog2(NCTX)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [FNW-1:0] look_fn_i,
    output logic           hit_o,
    output logic [CW-1:0]  hit_slot_o,
    input  logic           touch_i,
    input  logic           install_i,
    input  logic [FNW-1:0] install_fn_i,
    output logic [CW-1:0]  victim_o
);

    logic [NCTX-1:0][CW-1:0] age_q;
    logic [NCTX-1:0]         match_vec;
    logic [NCTX-1:0]         old_vec;
    logic [CW-1:0]           tslot;
    logic [CW-1:0]           tage;
    logic                    tupd;

    assign tupd  = touch_i || install_i;
    assign tslot = install_i ? victim_o : hit_slot_o;
    assign tage  = age_q[tslot];

    for (genvar g = 0; g < NCTX; g++) begin : g_ctx
        logic           cvld;
        logic [FNW-1:0] cfn;
        logic [CW-1:0]  age;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cvld <= 1'b0;
                cfn  <= '0;
                age  <= CW'(g);
            end else begin
                if (install_i && victim_o == CW'(g)) begin
                    cvld <= 1'b1;
                    cfn  <= install_fn_i;
                end
                if (tupd) begin
                    if (tslot == CW'(g))  age <= '0;
                    else if (age < tage)  age <= age + 1'b1;
                end
            end
        end

        assign age_q[g]     = age;
        assign match_vec[g] = cvld && (cfn == look_fn_i);
        assign old_vec[g]   = (age == CW'(NCTX - 1));
    end

    always_comb begin
        hit_slot_o = '0;
        victim_o   = '0;
        for (int i = NCTX - 1; i >= 0; i--) begin
            if (match_vec[i]) hit_slot_o = CW'(i);
            if (old_vec[i])   victim_o   = CW'(i);
        end
    end

    assign hit_o = |match_vec;

    // R9
    one_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(old_vec) == 1);

    // R8
    fill_touch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        install_i |-> !touch_i);

    // R9
    install_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        install_i |=> match_vec[$past(victim_o)] || ($past(install_fn_i) != look_fn_i));

endmodule

// File: rtl/mrh_scoreboard.sv
module mrh_scoreboard
    import mrh_pkg::*;
#(
    parameter int AW          = 16,
    parameter int LGW         = 4,
    parameter int NENT        = 4,
    parameter int NCTX        = 4,
    parameter int NFN         = 14,
    parameter int FILL_CYCLES = 4,
    localparam int TW  = $clog2(NENT),
    localparam int CW  = $clog2(NCTX),
    localparam int FNW = $clog2(NFN),
    localparam int FCW = $clog2(FILL_CYCLES + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cpu_req,
    input  logic           cpu_we,
    input  logic [AW-1:0]  cpu_addr,
    output logic           cpu_stall,
    input  logic           acc_req,
    input  logic [FNW-1:0] acc_fn,
    input  logic [AW-1:0]  acc_src,
    input  logic [LGW-1:0] acc_src_lg,
    input  logic [AW-1:0]  acc_dst,
    input  logic [LGW-1:0] acc_dst_lg,
    output logic           acc_stall,
    output logic           acc_grant,
    output logic [TW-1:0]  acc_tag,
    input  logic           done_valid,
    input  logic [TW-1:0]  done_tag,
    output logic           ctx_fill,
    output logic [CW-1:0]  ctx_fill_slot,
    output logic [FNW-1:0] ctx_fill_fn
);

    sb_state_e      state_q, state_d;
    logic [FCW-1:0] cnt_q, cnt_d;
    logic [FNW-1:0] fill_fn_q, fill_fn_d;
    logic           install;

    logic           cpu_hit;
    logic           op_hazard;
    logic           full;
    logic [TW-1:0]  free_tag;
    logic           ctx_hit;
    logic [CW-1:0]  hit_slot;
    logic [CW-1:0]  victim;

    mrh_region_table #(.AW(AW), .LGW(LGW), .NENT(NENT)) i_table (
        .clk            (clk),
        .rst_n          (rst_n),
        .alloc_i        (acc_grant),
        .alloc_src_i    (acc_src),
        .alloc_src_lg_i (acc_src_lg),
        .alloc_dst_i    (acc_dst),
        .alloc_dst_lg_i (acc_dst_lg),
        .done_i         (done_valid),
        .done_tag_i     (done_tag),
        .cpu_req_i      (cpu_req),
        .cpu_we_i       (cpu_we),
        .cpu_addr_i     (cpu_addr),
        .cpu_hit_o      (cpu_hit),
        .chk_src_i      (acc_src),
        .chk_src_lg_i   (acc_src_lg),
        .chk_dst_i      (acc_dst),
        .chk_dst_lg_i   (acc_dst_lg),
        .op_hazard_o    (op_hazard),
        .full_o         (full),
        .free_tag_o     (free_tag)
    );

    mrh_ctx_lru #(.NCTX(NCTX), .FNW(FNW)) i_ctx (
        .clk          (clk),
        .rst_n        (rst_n),
        .look_fn_i    (acc_fn),
        .hit_o        (ctx_hit),
        .hit_slot_o   (hit_slot),
        .touch_i      (acc_grant),
        .install_i    (install),
        .install_fn_i (fill_fn_q),
        .victim_o     (victim)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_RUN;
            cnt_q     <= '0;
            fill_fn_q <= '0;
        end else begin
            state_q   <= state_d;
            cnt_q     <= cnt_d;
            fill_fn_q <= fill_fn_d;
        end
    end

    // Next state
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        fill_fn_d = fill_fn_q;
        install   = 1'b0;
        unique case (state_q)
            S_RUN: begin
                if (acc_req && !ctx_hit) begin
                    state_d   = S_FILL;
                    cnt_d     = FCW'(FILL_CYCLES - 1);
                    fill_fn_d = acc_fn;
                end
            end
            S_FILL: begin
                if (cnt_q == '0) begin
                    state_d = S_RUN;
                    install = 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = S_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        acc_grant     = (state_q == S_RUN) && acc_req && ctx_hit && !op_hazard && !full;
        acc_stall     = acc_req && !acc_grant;
        acc_tag       = free_tag;
        cpu_stall     = cpu_hit;
        ctx_fill      = (state_q == S_FILL);
        ctx_fill_slot = victim;
        ctx_fill_fn   = fill_fn_q;
    end

    // R8
    miss_enters_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && acc_req && !ctx_hit) |=> (state_q == S_FILL));

    // R8
    fill_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FILL && cnt_q == '0) |=> (state_q == S_RUN));

    // R5
    grant_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_grant |-> (ctx_hit && !op_hazard));

    // R8
    fill_victim_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FILL && $past(state_q) == S_FILL) |-> $stable(victim));

endmodule

// File: tb/test_mrh_scoreboard.sv
module test_mrh_scoreboard;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_req, cpu_we;
    logic [15:0] cpu_addr;
    logic        cpu_stall;
    logic        acc_req;
    logic [3:0]  acc_fn;
    logic [15:0] acc_src, acc_dst;
    logic [3:0]  acc_src_lg, acc_dst_lg;
    logic        acc_stall, acc_grant;
    logic [1:0]  acc_tag;
    logic        done_valid;
    logic [1:0]  done_tag;
    logic        ctx_fill;
    logic [1:0]  ctx_fill_slot;
    logic [3:0]  ctx_fill_fn;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    int exp_tags[$];
    int last_fill_slot;

    always #2.5 clk = ~clk;

    mrh_scoreboard i_mrh_scoreboard (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_stall(cpu_stall),
        .acc_req(acc_req), .acc_fn(acc_fn), .acc_src(acc_src), .acc_src_lg(acc_src_lg),
        .acc_dst(acc_dst), .acc_dst_lg(acc_dst_lg), .acc_stall(acc_stall),
        .acc_grant(acc_grant), .acc_tag(acc_tag),
        .done_valid(done_valid), .done_tag(done_tag),
        .ctx_fill(ctx_fill), .ctx_fill_slot(ctx_fill_slot), .ctx_fill_fn(ctx_fill_fn)
    );

    task automatic check(string req, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Monitor: pops the expected tag on every grant.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && acc_grant) begin
                if (exp_tags.size() == 0) check("R5 unexpected grant", 1, 0);
                else check("R5 grant tag", int'(acc_tag), exp_tags.pop_front());
            end
        end
    end

    task automatic set_op(int fn, int s, int sl, int d, int dl);
        acc_fn = 4'(fn); acc_src = 16'(s); acc_src_lg = 4'(sl);
        acc_dst = 16'(d); acc_dst_lg = 4'(dl);
    endtask

    // Driver: offers an op, waits for its grant, returns cycles stalled.
    task automatic issue(int fn, int s, int sl, int d, int dl, int tag, output int waited);
        waited = 0;
        last_fill_slot = -1;
        exp_tags.push_back(tag);
        set_op(fn, s, sl, d, dl);
        acc_req = 1'b1;
        forever begin
            #1;
            if (acc_grant) break;
            if (ctx_fill) last_fill_slot = int'(ctx_fill_slot);
            @(negedge clk);
            waited++;
            if (waited > 50) break;
        end
        @(negedge clk);
        acc_req = 1'b0;
    endtask

    task automatic probe_stall(string req, int fn, int s, int sl, int d, int dl);
        set_op(fn, s, sl, d, dl);
        acc_req = 1'b1;
        #1;
        check(req, {acc_stall, acc_grant}, 2);
        acc_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic cpu_probe(string req, bit we, int addr, int exp);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = 16'(addr);
        #1;
        check(req, int'(cpu_stall), exp);
        cpu_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_op(int tag);
        done_valid = 1'b1; done_tag = 2'(tag);
        @(negedge clk);
        done_valid = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        int w;
        rst_n = 1'b0; cpu_req = 0; cpu_we = 0; cpu_addr = 0;
        acc_req = 0; done_valid = 0; done_tag = 0;
        set_op(0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        #1;
        check("R1 no fill", int'(ctx_fill), 0);
        check("R1 no stall", int'(acc_stall), 0);
        check("R1 no grant", int'(acc_grant), 0);
        @(negedge clk);
        cpu_probe("R1 store free", 1, 16'h2000, 0);

        // R1/R8/R9: first issue misses, fills context 3
        issue(0, 16'h1000, 8, 16'h2000, 8, 0, w);
        check("R8 miss latency", w, 5);
        check("R9 first victim", last_fill_slot, 3);

        // R2 / R3
        cpu_probe("R2 load in dst", 0, 16'h2010, 1);
        cpu_probe("R2 load in src", 0, 16'h1010, 0);
        cpu_probe("R3 store in src", 1, 16'h1010, 1);
        cpu_probe("R3 store in dst", 1, 16'h2080, 1);
        cpu_probe("R3 store outside", 1, 16'h3000, 0);

        // R4 mixed sizes
        issue(0, 16'h4000, 4, 16'h5000, 12, 1, w);
        check("R8 hit no wait", w, 0);
        cpu_probe("R4 load in big dst", 0, 16'h5ABC, 1);
        cpu_probe("R4 load past big dst", 0, 16'h6000, 0);

        // R5 op-to-op hazards
        probe_stall("R5 RAW", 0, 16'h5800, 2, 16'h7000, 4);
        probe_stall("R5 WAR", 0, 16'h8000, 4, 16'h1040, 4);
        probe_stall("R5 WAW", 0, 16'h8000, 4, 16'h20F0, 4);
        issue(0, 16'h8000, 4, 16'h9000, 4, 2, w);
        check("R5 disjoint wait", w, 0);
        issue(0, 16'hA000, 4, 16'hB000, 4, 3, w);

        // R6/R7 completion and issue in same cycle
        set_op(0, 16'hC000, 4, 16'hD000, 4);
        acc_req = 1'b1;
        done_valid = 1'b1; done_tag = 2'd1;
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 16'h5ABC;
        #1;
        check("R6 full stall", int'(acc_stall), 1);
        check("R7 load held in done cycle", int'(cpu_stall), 1);
        exp_tags.push_back(1);
        @(negedge clk);
        done_valid = 1'b0;
        #1;
        check("R6 granted after free", int'(acc_grant), 1);
        check("R7 load released", int'(cpu_stall), 0);
        @(negedge clk);
        acc_req = 1'b0; cpu_req = 1'b0;

        // R7 only own entry freed
        finish_op(3);
        cpu_probe("R7 freed store", 1, 16'hB004, 0);
        cpu_probe("R7 other still held", 1, 16'h9004, 1);
        finish_op(0); finish_op(1); finish_op(2);
        cpu_probe("R7 all free", 0, 16'h2010, 0);

        // R9 LRU order
        issue(1, 16'h0100, 4, 16'h0200, 4, 0, w); finish_op(0);
        check("R9 victim fn1", last_fill_slot, 2);
        issue(2, 16'h0100, 4, 16'h0200, 4, 0, w); finish_op(0);
        check("R9 victim fn2", last_fill_slot, 1);
        issue(3, 16'h0100, 4, 16'h0200, 4, 0, w); finish_op(0);
        check("R9 victim fn3", last_fill_slot, 0);
        issue(0, 16'h0100, 4, 16'h0200, 4, 0, w); finish_op(0);
        check("R9 fn0 resident", w, 0);
        issue(4, 16'h0100, 4, 16'h0200, 4, 0, w); finish_op(0);
        check("R9 evict fn1 slot", last_fill_slot, 2);
        check("R8 fill wait fn4", w, 5);
        issue(0, 16'h0100, 4, 16'h0200, 4, 0, w); finish_op(0);
        check("R9 fn0 kept", w, 0);
        issue(3, 16'h0100, 4, 16'h0200, 4, 0, w); finish_op(0);
        check("R9 fn3 kept", w, 0);
        issue(1, 16'h0100, 4, 16'h0200, 4, 0, w); finish_op(0);
        check("R9 fn1 refilled", w, 5);
        check("R9 evict fn2 slot", last_fill_slot, 1);
        issue(2, 16'h0100, 4, 16'h0200, 4, 0, w); finish_op(0);
        check("R9 fn2 was evicted", w, 5);

        repeat (3) @(negedge clk);
        check("R5 all grants seen", exp_tags.size(), 0);
        summary();
    end

endmodule